// File: doc/BRIEF.md
# Masked Interrupt Controller with Read-Clear

This block gathers sixteen event inputs into sticky flags and signals the host over an active-low interrupt line. A mask register selects which flags may pull the interrupt line low. Whatever the mask holds, every event still sets its flag. The host reaches the block through a serial slave port that is active while chip select is low. A frame begins with a command byte: bit 7 is 1 for a write and 0 for a read, and bits 6:0 carry the register address. Sixteen data bits follow. All bits travel MSB first. The block samples the input data on rising SCLK edges and changes its output data on falling edges.

The host can fetch the flags in two ways. A plain read leaves them untouched. A clearing read takes a snapshot of the flags at the end of the command byte, sends that snapshot, and at the end of the frame clears only the flags that were in it. While a clearing read is in progress, the interrupt line is held high. Events that arrive during that window are collected separately and merged back when the frame ends. No event is ever lost, so the line drops again at once if anything is still pending. If chip select rises before the frame is complete, the transfer is abandoned.

All logic runs on one system clock. The serial pins pass through two-flop synchronizers and are edge-detected in that clock domain.

Top module: `evt_irq_ctrl`

## Requirements
- R1: After reset the flags and the mask are zero and `irq_n_o` is high, so reads of address 0x0F and 0x10 return 0x0000.
- R2: A high cycle on `event_i[k]` sets flag k to 1 whatever mask bit k holds, and the flag stays set until a clearing read removes it.
- R3: Outside a clearing read, `irq_n_o` is low exactly when some flag k and mask bit k are both 1. It follows a new event or a completed mask write at the first clock edge after it.
- R4: Command byte 0x8F followed by 16 data bits writes the mask. Read command 0x0F returns the mask.
- R5: Read command 0x10 returns the flags, bit 15 first. It changes neither the flags nor `irq_n_o`.
- R6: Read command 0x11 returns the flags as they stood at the eighth falling SCLK edge. At the end of the frame it clears exactly the flags that were sent.
- R7: During a 0x11 frame, `irq_n_o` is high from the eighth falling SCLK edge (end of the command byte) up to the 24th falling edge (end of the data). After that it reflects the flags again.
- R8: An event arriving after the snapshot of a 0x11 frame, including one for a flag that is being cleared, is set in the flags when the frame ends.
- R9: If `spi_cs_n_i` rises before the 24th falling SCLK edge, the frame is abandoned. No flag is cleared, the forced-high state of `irq_n_o` ends, and events collected during the frame are kept.
- R10: Reads of any address other than 0x0F, 0x10 and 0x11 return 0x0000. Writes to any address other than 0x0F change nothing.
- R11: `spi_miso_o` is 0 while chip select is high. A frame cut short during its data bits writes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| event_i | input | NUM_SRC (16) | Event inputs, one per flag, synchronous to clk |
| spi_sclk_i | input | 1 | Serial clock, idles low |
| spi_cs_n_i | input | 1 | Active-low chip select; frames the command and data |
| spi_mosi_i | input | 1 | Serial data from the host, sampled on rising SCLK |
| spi_miso_o | output | 1 | Serial data to the host, updated on falling SCLK |
| irq_n_o | output | 1 | Active-low interrupt request |

## Verification
An event reaches `irq_n_o` at the first clock edge after the cycle in which it is high. The bench raises the event on a falling clock edge, drops it one cycle later, and checks the line straight away. A change on any serial pin takes effect at the third clock edge after it: two synchronizer stages, then the edge-detect stage. So the bench holds each SCLK phase for six clocks and samples `irq_n_o` and `spi_miso_o` only at the end of a phase, well after that latency. Read data is captured on each rising SCLK edge and compared with an expected word that the driver queued before the frame started.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;

  localparam int unsigned CMD_W  = 8;
  localparam int unsigned ADDR_W = 7;

  localparam logic [ADDR_W-1:0] REG_MASK     = 7'h0F;
  localparam logic [ADDR_W-1:0] REG_FLAGS    = 7'h10;
  localparam logic [ADDR_W-1:0] REG_FLAGS_RC = 7'h11;

  typedef struct packed {
    logic              wr;
    logic [ADDR_W-1:0] addr;
  } cmd_t;

endpackage

// File: rtl/evt_irq_sync.sv
module evt_irq_sync #(
  parameter int unsigned    W       = 3,
  parameter int unsigned    STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] pipe_q;
  logic [STAGES-1:0][W-1:0] pipe_d;

  generate
    if (STAGES > 1) begin : g_multi
      assign pipe_d = {pipe_q[STAGES-2:0], d};
    end else begin : g_single
      assign pipe_d = d;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= {STAGES{RST_VAL}};
    end else begin
      pipe_q <= pipe_d;
    end
  end

  assign q = pipe_q[STAGES-1];

endmodule

// File: rtl/evt_irq_spi.sv
module evt_irq_spi
  import evt_irq_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act,
  input  logic              cs_rel,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic              mosi,
  input  logic [DATA_W-1:0] rd_word,
  output logic              cmd_stb,
  output cmd_t              cmd_byte,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              done_stb,
  output logic              abort_stb,
  output logic              miso
);

  localparam int unsigned FRAME_BITS = CMD_W + DATA_W;
  localparam int unsigned CNT_W      = $clog2(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] CNT_CMD  = CNT_W'(CMD_W);
  localparam logic [CNT_W-1:0] CNT_END  = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_BITS - 1);

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] rx_q, rx_d;
  logic [DATA_W-1:0] tx_q, tx_d;
  cmd_t              cmd_q, cmd_d;
  logic              seen_q, seen_d;
  logic              done_q, done_d;

  assign cmd_byte = cmd_t'(rx_q[CMD_W-1:0]);

  always_comb begin
    cnt_d     = cnt_q;
    rx_d      = rx_q;
    tx_d      = tx_q;
    cmd_d     = cmd_q;
    seen_d    = seen_q;
    done_d    = done_q;
    cmd_stb   = 1'b0;
    done_stb  = 1'b0;
    abort_stb = 1'b0;
    if (!cs_act) begin
      cnt_d     = '0;
      tx_d      = '0;
      seen_d    = 1'b0;
      done_d    = 1'b0;
      abort_stb = cs_rel & seen_q & ~done_q;
    end else begin
      if (sck_rise && (cnt_q < CNT_END)) begin
        rx_d  = {rx_q[DATA_W-2:0], mosi};
        cnt_d = cnt_q + 1'b1;
      end
      if (sck_fall) begin
        if ((cnt_q == CNT_CMD) && !seen_q) begin
          cmd_stb = 1'b1;
          seen_d  = 1'b1;
          cmd_d   = cmd_byte;
          tx_d    = cmd_byte.wr ? '0 : rd_word;
        end else if ((cnt_q == CNT_END) && !done_q) begin
          done_stb = 1'b1;
          done_d   = 1'b1;
        end else if (seen_q && !done_q) begin
          tx_d = {tx_q[DATA_W-2:0], 1'b0};
        end
      end
    end
  end

  assign wr_stb  = cs_act & sck_rise & seen_q & ~done_q & cmd_q.wr & (cnt_q == CNT_LAST);
  assign wr_addr = cmd_q.addr;
  assign wr_data = {rx_q[DATA_W-2:0], mosi};
  assign miso    = tx_q[DATA_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      rx_q   <= '0;
      tx_q   <= '0;
      cmd_q  <= '0;
      seen_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      rx_q   <= rx_d;
      tx_q   <= tx_d;
      cmd_q  <= cmd_d;
      seen_q <= seen_d;
      done_q <= done_d;
    end
  end

endmodule

// File: rtl/evt_irq_regs.sv
module evt_irq_regs
  import evt_irq_pkg::*;
#(
  parameter int unsigned N = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      ev,
  input  logic              cmd_stb,
  input  cmd_t              cmd,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [N-1:0]      wr_data,
  input  logic              done_stb,
  input  logic              abort_stb,
  output logic [N-1:0]      rd_word,
  output logic              irq_n
);

  logic [N-1:0] flags_q, flags_d;
  logic [N-1:0] mask_q, mask_d;
  logic [N-1:0] pend_q, pend_d;
  logic [N-1:0] snap_q, snap_d;
  logic         busy_q, busy_d;
  logic         irq_n_q, irq_n_d;
  logic         rc_start;
  logic         mask_en;
  logic         snap_en;

  assign rc_start = cmd_stb & ~cmd.wr & (cmd.addr == REG_FLAGS_RC);
  assign mask_en  = wr_stb & (wr_addr == REG_MASK);
  assign snap_en  = rc_start;

  always_comb begin
    case (cmd.addr)
      REG_MASK:     rd_word = mask_q;
      REG_FLAGS:    rd_word = flags_q;
      REG_FLAGS_RC: rd_word = flags_q;
      default:      rd_word = '0;
    endcase
  end

  always_comb begin
    flags_d = flags_q;
    pend_d  = pend_q;
    busy_d  = busy_q;
    if (busy_q) begin
      if (done_stb) begin
        flags_d = (flags_q & ~snap_q) | pend_q | ev;
        pend_d  = '0;
        busy_d  = 1'b0;
      end else if (abort_stb) begin
        flags_d = flags_q | pend_q | ev;
        pend_d  = '0;
        busy_d  = 1'b0;
      end else begin
        pend_d = pend_q | ev;
      end
    end else begin
      flags_d = flags_q | ev;
    end
    if (rc_start) begin
      busy_d = 1'b1;
    end
  end

  assign snap_d  = flags_q;
  assign mask_d  = wr_data;
  assign irq_n_d = busy_d | ~(|(flags_d & (mask_en ? mask_d : mask_q)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      pend_q  <= '0;
      busy_q  <= 1'b0;
      irq_n_q <= 1'b1;
    end else begin
      flags_q <= flags_d;
      pend_q  <= pend_d;
      busy_q  <= busy_d;
      irq_n_q <= irq_n_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (mask_en) begin
      mask_q <= mask_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q <= '0;
    end else if (snap_en) begin
      snap_q <= snap_d;
    end
  end

  assign irq_n = irq_n_q;

endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
  import evt_irq_pkg::*;
#(
  parameter int unsigned NUM_SRC     = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] event_i,
  input  logic               spi_sclk_i,
  input  logic               spi_cs_n_i,
  input  logic               spi_mosi_i,
  output logic               spi_miso_o,
  output logic               irq_n_o
);

  localparam int unsigned PIN_W = 3;
  localparam logic [PIN_W-1:0] PIN_IDLE = 3'b010;

  logic [1:0]         rst_pipe_q;
  logic               rst_sync_n;
  logic [PIN_W-1:0]   pins_s;
  logic [1:0]         edge_q;
  logic               sck_s, cs_n_s, mosi_s;
  logic               sck_rise, sck_fall, cs_rel, cs_act;
  logic               cmd_stb_w, wr_stb_w, done_stb_w, abort_stb_w;
  cmd_t               cmd_byte_w;
  logic [ADDR_W-1:0]  wr_addr_w;
  logic [NUM_SRC-1:0] wr_data_w, rd_word_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe_q[1];

  evt_irq_sync #(
    .W       (PIN_W),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (PIN_IDLE)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d     ({spi_mosi_i, spi_cs_n_i, spi_sclk_i}),
    .q     (pins_s)
  );

  assign sck_s  = pins_s[0];
  assign cs_n_s = pins_s[1];
  assign mosi_s = pins_s[2];

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      edge_q <= PIN_IDLE[1:0];
    end else begin
      edge_q <= pins_s[1:0];
    end
  end

  assign sck_rise = sck_s & ~edge_q[0];
  assign sck_fall = ~sck_s & edge_q[0];
  assign cs_rel   = cs_n_s & ~edge_q[1];
  assign cs_act   = ~cs_n_s;

  evt_irq_spi #(
    .DATA_W (NUM_SRC)
  ) u_spi (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cs_act    (cs_act),
    .cs_rel    (cs_rel),
    .sck_rise  (sck_rise),
    .sck_fall  (sck_fall),
    .mosi      (mosi_s),
    .rd_word   (rd_word_w),
    .cmd_stb   (cmd_stb_w),
    .cmd_byte  (cmd_byte_w),
    .wr_stb    (wr_stb_w),
    .wr_addr   (wr_addr_w),
    .wr_data   (wr_data_w),
    .done_stb  (done_stb_w),
    .abort_stb (abort_stb_w),
    .miso      (spi_miso_o)
  );

  evt_irq_regs #(
    .N (NUM_SRC)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .ev        (event_i),
    .cmd_stb   (cmd_stb_w),
    .cmd       (cmd_byte_w),
    .wr_stb    (wr_stb_w),
    .wr_addr   (wr_addr_w),
    .wr_data   (wr_data_w),
    .done_stb  (done_stb_w),
    .abort_stb (abort_stb_w),
    .rd_word   (rd_word_w),
    .irq_n     (irq_n_o)
  );

endmodule

// File: rtl/evt_irq_chk.sv
module evt_irq_chk
  import evt_irq_pkg::*;
#(
  parameter int unsigned N = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N-1:0]      ev,
  input logic [N-1:0]      flags,
  input logic [N-1:0]      mask,
  input logic [N-1:0]      pend,
  input logic              busy,
  input logic              irq_n,
  input logic              cmd_stb,
  input logic              cmd_wr,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic              abort_stb,
  input logic              cs_act,
  input logic              miso
);

  AST_FORCED_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> irq_n); // R7

  AST_IRQ_ASSERTED: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && (|(flags & mask))) |-> !irq_n); // R3

  AST_IRQ_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !(|(flags & mask))) |-> irq_n); // R3

  AST_EVENT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && (|ev)) |=> ((flags & $past(ev)) == $past(ev))); // R2

  AST_EVENT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (|ev)) |=> (((flags | pend) & $past(ev)) == $past(ev))); // R8

  AST_PLAIN_NO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_stb && !cmd_wr && (cmd_addr == REG_FLAGS) && !busy)
      |=> (($past(flags) & ~flags) == '0)); // R5

  AST_ABORT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    abort_stb |=> (!busy && (($past(flags) & ~flags) == '0))); // R9

  AST_MISO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> !miso); // R11

endmodule

bind evt_irq_ctrl evt_irq_chk #(
  .N (NUM_SRC)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .ev        (event_i),
  .flags     (u_regs.flags_q),
  .mask      (u_regs.mask_q),
  .pend      (u_regs.pend_q),
  .busy      (u_regs.busy_q),
  .irq_n     (irq_n_o),
  .cmd_stb   (cmd_stb_w),
  .cmd_wr    (cmd_byte_w.wr),
  .cmd_addr  (cmd_byte_w.addr),
  .abort_stb (abort_stb_w),
  .cs_act    (cs_act),
  .miso      (spi_miso_o)
);

// File: tb/evt_irq_ctrl_tb_top.sv
module evt_irq_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int HALF_SCK   = 6;
  localparam int NS         = 16;

  typedef struct {
    bit          cmp;
    logic [15:0] word;
    string       req;
  } exp_t;

  logic          clk;
  logic          rst_n;
  logic [NS-1:0] ev;
  logic          sck, cs_n, mosi;
  logic          miso, irq_n;

  int   n_vec;
  int   n_bad;
  bit   finished;
  exp_t exp_q[$];
  logic irq_pre, irq_mid, irq_last;

  evt_irq_ctrl dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .event_i    (ev),
    .spi_sclk_i (sck),
    .spi_cs_n_i (cs_n),
    .spi_mosi_i (mosi),
    .spi_miso_o (miso),
    .irq_n_o    (irq_n)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  // monitor: gathers the 16 data bits of each frame and pops the scoreboard
  int          mon_cnt;
  logic [15:0] mon_sh;
  always @(posedge sck or posedge cs_n) begin
    if (cs_n) begin
      mon_cnt = 0;
    end else begin
      mon_sh = {mon_sh[14:0], miso};
      mon_cnt++;
      if (mon_cnt == 24) begin
        if (exp_q.size() == 0) begin
          chk("scoreboard underflow", 1, 0);
        end else begin
          exp_t it;
          it = exp_q.pop_front();
          if (it.cmp) chk(it.req, mon_sh, it.word);
        end
      end
    end
  end

  task automatic frame(input logic [7:0] cmd, input logic [15:0] data, input int nbits,
                       input int ev_bit, input logic [15:0] ev_val);
    logic [23:0] word;
    word = {cmd, data};
    @(negedge clk) cs_n = 1'b0;
    repeat (HALF_SCK) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      mosi = word[23-i];
      repeat (HALF_SCK) @(negedge clk);
      sck = 1'b1;
      if (i == ev_bit) begin
        ev = ev_val;
        @(negedge clk);
        ev = '0;
        repeat (HALF_SCK - 1) @(negedge clk);
      end else begin
        repeat (HALF_SCK) @(negedge clk);
      end
      if (i == 7) irq_pre = irq_n;
      if (i == 12) irq_mid = irq_n;
      if (i == nbits - 1) irq_last = irq_n;
      sck = 1'b0;
    end
    repeat (HALF_SCK) @(negedge clk);
    cs_n = 1'b1;
    repeat (HALF_SCK) @(negedge clk);
  endtask

  task automatic rd(input logic [7:0] cmd, input logic [15:0] exp, input string req);
    exp_t it;
    it.cmp = 1'b1; it.word = exp; it.req = req;
    exp_q.push_back(it);
    frame(cmd, 16'h0000, 24, -1, '0);
  endtask

  task automatic wr(input logic [6:0] addr, input logic [15:0] data);
    exp_t it;
    it.cmp = 1'b0; it.word = '0; it.req = "write";
    exp_q.push_back(it);
    frame({1'b1, addr}, data, 24, -1, '0);
  endtask

  task automatic ev_pulse(input logic [15:0] val);
    @(negedge clk) ev = val;
    @(negedge clk) ev = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    report();
  end

  initial begin
    n_vec = 0; n_bad = 0; finished = 1'b0;
    rst_n = 1'b0; ev = '0; sck = 1'b0; cs_n = 1'b1; mosi = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    chk("R1 irq idle after reset", irq_n, 1);
    rd(8'h0F, 16'h0000, "R1 mask reset");
    rd(8'h10, 16'h0000, "R1 flags reset");
    chk("R11 miso quiet", miso, 0);

    ev_pulse(16'h0001);
    chk("R2 masked event leaves irq high", irq_n, 1);
    rd(8'h10, 16'h0001, "R2 flag set while masked");

    wr(7'h0F, 16'h00F0);
    rd(8'h0F, 16'h00F0, "R4 mask readback");
    chk("R3 unmasked flag absent", irq_n, 1);
    ev_pulse(16'h0020);
    chk("R3 irq low next edge", irq_n, 0);

    rd(8'h10, 16'h0021, "R5 plain read");
    chk("R5 no forcing during plain read", irq_mid, 0);
    chk("R5 irq unchanged after plain read", irq_n, 0);

    rd(8'h11, 16'h0021, "R6 clearing read data");
    chk("R7 irq low before command end", irq_pre, 0);
    chk("R7 irq forced mid data", irq_mid, 1);
    chk("R7 irq forced at last bit", irq_last, 1);
    chk("R7 irq high after clear", irq_n, 1);
    rd(8'h10, 16'h0000, "R6 flags cleared");

    ev_pulse(16'h0020);
    chk("R3 irq low again", irq_n, 0);
    begin
      exp_t it;
      it.cmp = 1'b1; it.word = 16'h0020; it.req = "R8 snapshot excludes late event";
      exp_q.push_back(it);
    end
    frame(8'h11, 16'h0000, 24, 14, 16'h0060);
    chk("R7 forced through late event", irq_last, 1);
    chk("R8 irq returns for pending", irq_n, 0);
    rd(8'h10, 16'h0060, "R8 late events kept");

    frame(8'h11, 16'h0000, 14, 10, 16'h0100);
    chk("R9 forced before abort", irq_mid, 1);
    chk("R9 force released by abort", irq_n, 0);
    rd(8'h10, 16'h0160, "R9 nothing cleared by abort");

    begin
      exp_t it;
      it.cmp = 1'b1; it.word = 16'h8160; it.req = "R6 event before command end in snapshot";
      exp_q.push_back(it);
    end
    frame(8'h11, 16'h0000, 24, 3, 16'h8000);
    chk("R7 irq high after full clear", irq_n, 1);
    rd(8'h10, 16'h0000, "R6 all snapshot flags cleared");

    ev_pulse(16'h0100);
    chk("R3 flag outside mask", irq_n, 1);
    wr(7'h0F, 16'h0100);
    chk("R3 mask write asserts irq", irq_n, 0);
    wr(7'h0F, 16'h0000);
    chk("R3 mask clear releases irq", irq_n, 1);

    rd(8'h05, 16'h0000, "R10 unknown address");
    wr(7'h10, 16'hFFFF);
    rd(8'h10, 16'h0100, "R10 write to flags ignored");
    rd(8'h0F, 16'h0000, "R10 mask untouched");

    frame(8'h8F, 16'hFFFF, 15, -1, '0);
    rd(8'h0F, 16'h0000, "R11 short write frame");
    chk("R11 miso quiet after frames", miso, 0);

    repeat (20) @(negedge clk);
    chk("scoreboard drained", exp_q.size(), 0);
    report();
  end

endmodule